// File: doc/BRIEF.md
# Shared-Bus Burst SRAM Controller

This block sits on the memory side of an external SRAM device whose single 32-bit bus carries both the address and the data. A transfer opens with one address word, tagged by a strobe from the bus master. Data words follow on the same wires: a single word for an uncached access, or eight words for a cache-line refill or write-back. Sending one address per eight-word line spreads the cost of the address beat across the whole line, while a single-word access still pays one address beat for one data beat.

The controller generates the half-rate bus beat from the processor clock. On each beat it decodes the address word and compares its device-select field against its own identity. It then steps through the write beats or the read beats, with the line offset wrapping inside the aligned eight-word line. Storage is a behavioural array built as an eight-by-eight grid of equal sub-arrays. On a read, one idle beat separates the master's address from the controller's first data word.

Top module: `mad_burst_ctrl`

## Requirements
- R1: During and after reset, bus_oe is 0 and bus_out is 0, and the first address word presented on a beat is accepted.
- R2: bus_tick is 0 in the first cycle after reset and alternates every clock thereafter. The controller samples the bus, and updates bus_oe and bus_out, only on clock edges where bus_tick is 1.
- R3: Address word layout: bit 31 = 1 for write, bit 30 = 1 for an eight-word burst (0 for one word), bits 29:26 = device select, bits 9:0 = word address (default parameters). Bits 25:10 are ignored.
- R4: An address word whose device-select field differs from DEV_ID (default 5) leaves bus_oe at 0, bus_out at 0 and the storage unchanged, and the controller stays ready for the next address.
- R5: A single write stores the one data word that follows the address beat at the addressed word.
- R6: A burst write stores eight consecutive data beats at word offsets base+0 to base+7 taken modulo 8 within the aligned eight-word line. The upper address bits stay unchanged.
- R7: After a read address beat, the controller holds the bus released (bus_oe 0) for exactly one beat. It then drives the first data word.
- R8: A burst read drives eight data beats in the same wrapping order as R6. A single read drives one.
- R9: In the beat after the last read data word, bus_oe returns to 0. bus_out is 0 whenever bus_oe is 0.
- R10: While a transfer is in progress, addr_phase is ignored, and every beat of a write burst is taken as data.
- R11: Words whose addresses differ only in the grid row bits (9:7) or column bits (6:4) are held independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_phase | input | 1 | High while the master drives an address word |
| bus_in | input | 32 | Value the master drives on the shared bus |
| bus_tick | output | 1 | Half-rate beat strobe; a beat completes on edges where it is 1 |
| bus_oe | output | 1 | High while the controller drives the shared bus |
| bus_out | output | 32 | Read data driven onto the shared bus |

## Verification
On every cycle, the assertions check that the beat strobe alternates and that the bus outputs move only on beat edges. They also check that a released bus reads zero and that bus drive never begins except straight out of the turnaround beat. Three further per-cycle checks cover the ongoing transfer: the line base address holds steady, an unselected address word never leaves the idle state, and a write never turns on the driver. Only the bench's scenarios can show that the right words land at the right wrapped offsets, that rows and columns of the grid are independent, and that a strobe in the middle of a write burst is stored as data.

// File: rtl/mad_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the shared-bus burst controller: bus word field
// positions and the bus sequencer state type. Assumes a 32-bit bus word.
package mad_pkg;
    localparam int WORD_W   = 32;
    localparam int F_WR     = 31;  // write flag bit
    localparam int F_BURST  = 30;  // eight-word burst flag bit
    localparam int F_SEL_LO = 26;  // lowest device-select bit
    localparam int SEL_W    = 4;   // device-select field width

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WDATA = 2'd1,
        S_TURN  = 2'd2,
        S_RDATA = 2'd3
    } bus_state_t;
endpackage

// File: rtl/mad_beat_gen.sv
`timescale 1ns/1ps
// Half-rate beat generator. Produces a strobe that is high on every second
// processor clock, so the bus side advances at half the core rate.
// Assumes a synchronous active-low reset; the strobe is low right after reset.
module mad_beat_gen (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    // Toggle once per clock to divide the rate by two.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end
endmodule

// File: rtl/mad_addr_decode.sv
`timescale 1ns/1ps
// Address word decoder. Splits the fields of an address word and compares
// the device-select field with this device's identity.
// Assumes the caller passes only the fields the decode needs.
module mad_addr_decode
    import mad_pkg::*;
#(
    parameter int                WA_W   = 10,
    parameter logic [SEL_W-1:0]  DEV_ID = 4'd5
) (
    input  logic             wr_bit,
    input  logic             burst_bit,
    input  logic [SEL_W-1:0] sel_field,
    input  logic [WA_W-1:0]  wa_field,
    output logic             hit,
    output logic             is_wr,
    output logic             is_burst,
    output logic [WA_W-1:0]  word_addr
);
    // Combine the field values into the decoded command.
    always_comb begin
        hit       = (sel_field == DEV_ID);
        is_wr     = wr_bit;
        is_burst  = burst_bit;
        word_addr = wa_field;
    end
endmodule

// File: rtl/mad_mem_grid.sv
`timescale 1ns/1ps
// Behavioural storage built as a square grid of equal sub-arrays. The top
// GRID_BITS of the word address pick the row, the next GRID_BITS pick the
// column and the low SUB_AW bits pick the word inside the sub-array.
// Assumes one write port and one asynchronous read port; the contents have no reset.
module mad_mem_grid
    import mad_pkg::*;
#(
    parameter int SUB_AW    = 4,
    parameter int GRID_BITS = 3,
    localparam int IDX_W    = 2 * GRID_BITS,
    localparam int WA_W     = SUB_AW + IDX_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [WA_W-1:0]   waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WA_W-1:0]   raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int NSUB      = 1 << IDX_W;
    localparam int SUB_DEPTH = 1 << SUB_AW;

    logic [IDX_W-1:0]  wsel;
    logic [IDX_W-1:0]  rsel;
    logic [WORD_W-1:0] sub_rd [NSUB];

    assign wsel = waddr[WA_W-1:SUB_AW];
    assign rsel = raddr[WA_W-1:SUB_AW];

    for (genvar g = 0; g < NSUB; g++) begin : g_sub
        logic [WORD_W-1:0] arr [SUB_DEPTH];

        // Store a word when this sub-array is the write target.
        always_ff @(posedge clk) begin
            if (we && (wsel == IDX_W'(g)))
                arr[waddr[SUB_AW-1:0]] <= wdata;
        end

        assign sub_rd[g] = arr[raddr[SUB_AW-1:0]];
    end

    assign rdata = sub_rd[rsel];
endmodule

// File: rtl/mad_bus_fsm.sv
`timescale 1ns/1ps
// Bus sequencer. On each beat it accepts an address word when idle, then
// runs the write or read data beats. It inserts one released beat before
// read data and wraps the line offset inside the aligned line.
// Assumes the decoder output is valid in the beat the address is strobed.
module mad_bus_fsm
    import mad_pkg::*;
#(
    parameter int  WA_W      = 10,
    parameter int  LINE_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              addr_phase,
    input  logic              hit,
    input  logic              is_wr,
    input  logic              is_burst,
    input  logic [WA_W-1:0]   word_addr,
    input  logic [WORD_W-1:0] rdata,
    output logic              mem_we,
    output logic [WA_W-1:0]   cur_addr,
    output logic [WORD_W-1:0] drv_data,
    output logic              drv_en,
    output bus_state_t        state
);
    localparam logic [LINE_BITS-1:0] LAST_BEAT = '1;

    logic [LINE_BITS-1:0] left_q;
    logic [WA_W-1:0]      next_addr;

    // Step the line offset by one word and keep the line base fixed.
    always_comb begin
        next_addr = {cur_addr[WA_W-1:LINE_BITS],
                     LINE_BITS'(cur_addr[LINE_BITS-1:0] + 1'b1)};
    end

    // Write strobe for storage: one word per data beat of a write.
    assign mem_we = tick && (state == S_WDATA);

    // Sequence the transfer one beat at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_addr <= '0;
            left_q   <= '0;
            drv_data <= '0;
            drv_en   <= 1'b0;
        end else if (tick) begin
            case (state)
                S_IDLE: begin
                    if (addr_phase && hit) begin
                        cur_addr <= word_addr;
                        left_q   <= is_burst ? LAST_BEAT : '0;
                        state    <= is_wr ? S_WDATA : S_TURN;
                    end
                end
                S_WDATA: begin
                    cur_addr <= next_addr;
                    if (left_q == '0) state  <= S_IDLE;
                    else              left_q <= left_q - 1'b1;
                end
                S_TURN: begin
                    drv_data <= rdata;
                    drv_en   <= 1'b1;
                    cur_addr <= next_addr;
                    state    <= S_RDATA;
                end
                S_RDATA: begin
                    if (left_q == '0) begin
                        drv_data <= '0;
                        drv_en   <= 1'b0;
                        state    <= S_IDLE;
                    end else begin
                        drv_data <= rdata;
                        cur_addr <= next_addr;
                        left_q   <= left_q - 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mad_burst_ctrl.sv
`timescale 1ns/1ps
// Memory-side controller for an SRAM device on a shared address/data bus.
// Generates the half-rate beat, decodes address words, sequences single and
// eight-word bursts, and drives read data onto the bus.
// Assumes the master drives bus_in and addr_phase stable across each beat
// and does not drive the bus while bus_oe is high.
module mad_burst_ctrl
    import mad_pkg::*;
#(
    parameter int               SUB_AW    = 4,
    parameter int               GRID_BITS = 3,
    parameter int               LINE_BITS = 3,
    parameter logic [SEL_W-1:0] DEV_ID    = 4'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_phase,
    input  logic [WORD_W-1:0] bus_in,
    output logic              bus_tick,
    output logic              bus_oe,
    output logic [WORD_W-1:0] bus_out
);
    localparam int WA_W = SUB_AW + 2 * GRID_BITS;

    logic              dec_hit;
    logic              dec_wr;
    logic              dec_burst;
    logic [WA_W-1:0]   dec_addr;
    logic              mem_we;
    logic [WORD_W-1:0] mem_rdata;
    logic [WA_W-1:0]   fsm_addr;
    bus_state_t        fsm_state;

    mad_beat_gen u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bus_tick)
    );

    mad_addr_decode #(
        .WA_W   (WA_W),
        .DEV_ID (DEV_ID)
    ) u_dec (
        .wr_bit    (bus_in[F_WR]),
        .burst_bit (bus_in[F_BURST]),
        .sel_field (bus_in[F_SEL_LO +: SEL_W]),
        .wa_field  (bus_in[WA_W-1:0]),
        .hit       (dec_hit),
        .is_wr     (dec_wr),
        .is_burst  (dec_burst),
        .word_addr (dec_addr)
    );

    mad_bus_fsm #(
        .WA_W      (WA_W),
        .LINE_BITS (LINE_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bus_tick),
        .addr_phase (addr_phase),
        .hit        (dec_hit),
        .is_wr      (dec_wr),
        .is_burst   (dec_burst),
        .word_addr  (dec_addr),
        .rdata      (mem_rdata),
        .mem_we     (mem_we),
        .cur_addr   (fsm_addr),
        .drv_data   (bus_out),
        .drv_en     (bus_oe),
        .state      (fsm_state)
    );

    mad_mem_grid #(
        .SUB_AW    (SUB_AW),
        .GRID_BITS (GRID_BITS)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (fsm_addr),
        .wdata (bus_in),
        .raddr (fsm_addr),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/mad_burst_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for the shared-bus burst controller, bound into the top.
// Assumes the state and line-base signals of the top are passed in.
module mad_burst_ctrl_chk
    import mad_pkg::*;
#(
    parameter int               LB_W   = 7,
    parameter logic [SEL_W-1:0] DEV_ID = 4'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick,
    input  logic              addr_phase,
    input  logic [SEL_W-1:0]  sel_field,
    input  logic              bus_oe,
    input  logic [WORD_W-1:0] bus_out,
    input  bus_state_t        st,
    input  logic [LB_W-1:0]   line_base
);
    a_r2_tick_falls: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tick |=> !bus_tick);

    a_r2_tick_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_tick |=> bus_tick);

    a_r2_hold_off_beat: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_tick |=> ($stable(bus_oe) && $stable(bus_out)));

    a_r7_drive_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> ($past(st) == S_TURN));

    a_r9_released_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    a_r4_unselected_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tick && st == S_IDLE && addr_phase && sel_field != DEV_ID)
            |=> (st == S_IDLE));

    a_r6_line_base_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> $stable(line_base));

    a_r10_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WDATA) |-> !bus_oe);
endmodule

bind mad_burst_ctrl mad_burst_ctrl_chk #(
    .LB_W   (WA_W - LINE_BITS),
    .DEV_ID (DEV_ID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_tick   (bus_tick),
    .addr_phase (addr_phase),
    .sel_field  (bus_in[mad_pkg::F_SEL_LO +: mad_pkg::SEL_W]),
    .bus_oe     (bus_oe),
    .bus_out    (bus_out),
    .st         (fsm_state),
    .line_base  (fsm_addr[WA_W-1:LINE_BITS])
);

// File: tb/tb_mad_burst_ctrl.sv
`timescale 1ns/1ps
// Directed bench for the shared-bus burst controller.
module tb_mad_burst_ctrl;
    localparam int WA_W = 10;
    localparam logic [3:0] DEV = 4'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_phase = 1'b0;
    logic [31:0] bus_in = '0;
    logic        bus_tick;
    logic        bus_oe;
    logic [31:0] bus_out;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [31:0] ref_mem [1 << WA_W];

    always #2 clk = ~clk;  // 250 MHz

    mad_burst_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_phase (addr_phase),
        .bus_in     (bus_in),
        .bus_tick   (bus_tick),
        .bus_oe     (bus_oe),
        .bus_out    (bus_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit wr, input bit burst,
                                        input logic [3:0] dev, input logic [WA_W-1:0] wa,
                                        input logic [15:0] junk);
        return {wr, burst, dev, junk, wa};
    endfunction

    function automatic logic [WA_W-1:0] wrap(input logic [WA_W-1:0] base, input int i);
        return {base[WA_W-1:3], 3'(base[2:0] + i)};
    endfunction

    // One beat: drive at a negedge where bus_tick is 0, return after the beat edge.
    task automatic beat(input bit ap, input logic [31:0] w);
        addr_phase = ap;
        bus_in     = w;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [WA_W-1:0] wa, input bit burst,
                            input logic [31:0] seed, input int strobe_at, input string req);
        int n = burst ? 8 : 1;
        beat(1'b1, mk(1'b1, burst, DEV, wa, 16'h0));
        for (int i = 0; i < n; i++) begin
            logic [31:0] d = seed + 32'h0101_0101 * i;
            beat(i == strobe_at, d);
            ref_mem[wrap(wa, i)] = d;
            chk({req, " no drive in write"}, {31'b0, bus_oe}, 32'd0);
        end
        addr_phase = 1'b0;
        bus_in     = '0;
    endtask

    task automatic do_read(input logic [WA_W-1:0] wa, input bit burst,
                           input logic [15:0] junk, input string req);
        int n = burst ? 8 : 1;
        beat(1'b1, mk(1'b0, burst, DEV, wa, junk));
        chk("R7 turnaround beat released", {31'b0, bus_oe}, 32'd0);
        for (int i = 0; i < n; i++) begin
            beat(1'b0, 32'h0);
            chk({req, " drive enable"}, {31'b0, bus_oe}, 32'd1);
            chk({req, " data"}, bus_out, ref_mem[wrap(wa, i)]);
        end
        beat(1'b0, 32'h0);
        chk("R9 released after last beat", {31'b0, bus_oe}, 32'd0);
        chk("R9 released bus is zero", bus_out, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 oe in reset", {31'b0, bus_oe}, 32'd0);
        chk("R1 out in reset", bus_out, 32'd0);
        chk("R2 tick low in reset", {31'b0, bus_tick}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 tick after first edge", {31'b0, bus_tick}, 32'd1);
        @(negedge clk);
        chk("R2 tick alternates", {31'b0, bus_tick}, 32'd0);
        @(negedge clk);
        chk("R2 tick alternates again", {31'b0, bus_tick}, 32'd1);
        @(negedge clk);
        chk("R1 oe after reset", {31'b0, bus_oe}, 32'd0);
    endtask

    task automatic t_single;
        do_write(10'h123, 1'b0, 32'hCAFE_0001, -1, "R5");
        do_read(10'h123, 1'b0, 16'h0, "R5 R8 single read");
    endtask

    task automatic t_burst_wrap;
        do_write(10'h015, 1'b1, 32'h1000_0000, -1, "R6");
        do_read(10'h015, 1'b1, 16'h0, "R6 R8 wrapped burst");
        do_read(10'h013, 1'b1, 16'h0, "R8 burst other start");
    endtask

    task automatic t_unselected;
        do_write(10'h200, 1'b0, 32'hAAAA_5555, -1, "R4 setup");
        beat(1'b1, mk(1'b1, 1'b0, 4'd6, 10'h200, 16'h0));
        chk("R4 unselected no drive", {31'b0, bus_oe}, 32'd0);
        beat(1'b0, 32'hDEAD_BEEF);
        chk("R4 unselected out zero", bus_out, 32'd0);
        beat(1'b1, mk(1'b0, 1'b0, 4'd6, 10'h200, 16'h0));
        beat(1'b0, 32'h0);
        chk("R4 unselected read no drive", {31'b0, bus_oe}, 32'd0);
        beat(1'b0, 32'h0);
        do_read(10'h200, 1'b0, 16'h0, "R4 storage unchanged");
    endtask

    task automatic t_strobe_in_write;
        do_write(10'h0A8, 1'b1, 32'h7700_0000, 3, "R10");
        do_read(10'h0A8, 1'b1, 16'h0, "R10 strobe taken as data");
    endtask

    task automatic t_grid_and_fields;
        do_write(10'h000, 1'b0, 32'h0000_0A00, -1, "R11");
        do_write(10'h380, 1'b0, 32'h0000_0B00, -1, "R11");
        do_write(10'h070, 1'b0, 32'h0000_0C00, -1, "R11");
        do_write(10'h3F0, 1'b0, 32'h0000_0D00, -1, "R11");
        do_read(10'h000, 1'b0, 16'h0, "R11 row0 col0");
        do_read(10'h380, 1'b0, 16'h0, "R11 row7 col0");
        do_read(10'h070, 1'b0, 16'h0, "R11 row0 col7");
        do_read(10'h3F0, 1'b0, 16'h0, "R11 row7 col7");
        do_read(10'h070, 1'b0, 16'hFFFF, "R3 ignored bits");
    endtask

    initial begin
        t_reset();
        t_single();
        t_burst_wrap();
        t_unselected();
        t_strobe_in_write();
        t_grid_and_fields();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule